// File: doc/BRIEF.md
# Configurable 16-Pin GPIO Port

This block controls one bidirectional port of general-purpose pins. Software programs four per-pin registers: a data buffer, a direction mask, an attribute mask and an alternate-function mask. It also programs a small port configuration register that holds an alternate-set select bit and a wakeup-enable bit. From these values the block drives each pad's output enable, output level and pull controls. The attribute bit takes a different meaning for each direction. On an input it chooses between a resistor pull and a floating pin, and the data bit then sets the pull direction. On an output it chooses between inverted and true drive of the data bit.

A pin whose alternate-function mask bit is set is handed to one of two peripheral sets. The select bit in the configuration register chooses the set. Pin inputs pass through a two-flop synchronizer. Software can read back either the stored data buffer or the synchronized live pin level, at separate addresses. When wakeup is enabled, any change of the synchronized pin value raises a one-cycle wake pulse for the system's sleep controller.

The register bus is synchronous. A write takes effect at the clock edge where `bus_we` is high. Read data is registered and appears one cycle after the address is presented. All pad outputs are registered, so they follow a register write by one further cycle.

Top module: `gpio_port_ctl`

## Requirements
- R1: After reset all registers are 0. Every pin is then an input with a pull-down: pad_oe 0, pad_pull_en all ones, pad_pull_up 0. wake_pulse and bus_rdata are 0.
- R2: In GPIO mode (mask bit 0), a direction bit of 1 sets that pin's pad_oe to 1, and a direction bit of 0 sets it to 0. Pad outputs follow a register write one cycle after the write edge.
- R3: A GPIO output pin with attribute bit 0 drives the inverse of its data bit on pad_out.
- R4: A GPIO output pin with attribute bit 1 drives its data bit unchanged on pad_out.
- R5: A GPIO input pin with attribute bit 0 has pad_pull_en 1, and pad_pull_up equals its data bit (1 = pull-up, 0 = pull-down).
- R6: A GPIO input pin with attribute bit 1 floats: pad_pull_en 0 and pad_pull_up 0. A driven pin (output or alternate) never has its pull enabled.
- R7: The register map is data 0, direction 1, attribute 2, mask 3, pin level 4, config 5. In config, bit 0 is the alternate-set select and bit 1 is wakeup enable. Reading addresses 0, 1, 2, 3 or 5 returns the stored value on bus_rdata one cycle after the address, with the unused config bits read as 0.
- R8: Reading address 4 returns the pin level after the two-flop synchronizer. A change on pin_in becomes visible on bus_rdata at the third clock edge while address 4 is held.
- R9: A pin with mask bit 1 takes pad_oe and pad_out from alt0 when config bit 0 is 0, and from alt1 when it is 1. Its pulls are off.
- R10: With config bit 1 set, any change of the synchronized pins raises wake_pulse for exactly one cycle, at the third edge after the pin change. With the bit clear there is no pulse. The enable in effect is the one held before that edge.
- R11: Writes to address 4, 6 or 7 change no state. Reads of addresses 6 and 7 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| pin_in | input | 16 | Asynchronous pad input levels |
| alt0_out | input | 16 | Alternate set 0 output values |
| alt0_oe | input | 16 | Alternate set 0 output enables |
| alt1_out | input | 16 | Alternate set 1 output values |
| alt1_oe | input | 16 | Alternate set 1 output enables |
| pad_oe | output | 16 | Pad output enable |
| pad_out | output | 16 | Pad output value |
| pad_pull_en | output | 16 | Pad pull resistor enable |
| pad_pull_up | output | 16 | Pad pull direction, 1 = up |
| wake_pulse | output | 1 | One-cycle wakeup request |

## Verification
Two functions can fall in the same clock edge: a bus write of the wakeup-enable bit, and the wake detector seeing the synchronized pins change. The bench changes a pin and then times a config write so that it lands on the exact edge where the change reaches the comparator. A correct design gives no pulse on that edge, because the old enable applies. A second pin change afterwards must then give a pulse. Separately, a live-pin read is held across a wake event, which checks that the read path and the pulse both respect the synchronizer latency.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int REG_ADDR_W = 3;
  localparam int CFG_W      = 2;

  localparam logic [REG_ADDR_W-1:0] ADDR_DATA = 3'd0;
  localparam logic [REG_ADDR_W-1:0] ADDR_DIR  = 3'd1;
  localparam logic [REG_ADDR_W-1:0] ADDR_ATTR = 3'd2;
  localparam logic [REG_ADDR_W-1:0] ADDR_MASK = 3'd3;
  localparam logic [REG_ADDR_W-1:0] ADDR_PIN  = 3'd4;
  localparam logic [REG_ADDR_W-1:0] ADDR_CFG  = 3'd5;

  localparam int CFG_ALT_SEL = 0;
  localparam int CFG_WAKE_EN = 1;
endpackage

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int PIN_W = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  we,
  input  logic [REG_ADDR_W-1:0] addr,
  input  logic [PIN_W-1:0]      wdata,
  input  logic [PIN_W-1:0]      pin_level,
  output logic [PIN_W-1:0]      rdata,
  output logic [PIN_W-1:0]      data_q,
  output logic [PIN_W-1:0]      dir_q,
  output logic [PIN_W-1:0]      attr_q,
  output logic [PIN_W-1:0]      mask_q,
  output logic [CFG_W-1:0]      cfg_q
);
  // Register storage
  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      dir_q  <= '0;
      attr_q <= '0;
      mask_q <= '0;
      cfg_q  <= '0;
    end else if (we) begin
      case (addr)
        ADDR_DATA: data_q <= wdata;
        ADDR_DIR:  dir_q  <= wdata;
        ADDR_ATTR: attr_q <= wdata;
        ADDR_MASK: mask_q <= wdata;
        ADDR_CFG:  cfg_q  <= wdata[CFG_W-1:0];
        default: ;
      endcase
    end
  end

  // Registered read port
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      case (addr)
        ADDR_DATA: rdata <= data_q;
        ADDR_DIR:  rdata <= dir_q;
        ADDR_ATTR: rdata <= attr_q;
        ADDR_MASK: rdata <= mask_q;
        ADDR_PIN:  rdata <= pin_level;
        ADDR_CFG:  rdata <= PIN_W'(cfg_q);
        default:   rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_port_sync.sv
module gpio_port_sync #(
  parameter int PIN_W  = 16,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PIN_W-1:0] pin_raw,
  output logic [PIN_W-1:0] pin_sync,
  output logic [PIN_W-1:0] pin_hist
);
  localparam int LAST = STAGES - 1;

  logic [PIN_W-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= '0;
          else     stage_q[s] <= pin_raw;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= '0;
          else     stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  // One-cycle history of the synchronized value for change detection
  always_ff @(posedge clk) begin
    if (rst) pin_hist <= '0;
    else     pin_hist <= stage_q[LAST];
  end

  assign pin_sync = stage_q[LAST];
endmodule

// File: rtl/gpio_port_wake.sv
module gpio_port_wake #(
  parameter int PIN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic [PIN_W-1:0] pin_sync,
  input  logic [PIN_W-1:0] pin_hist,
  output logic             wake
);
  logic activity;

  assign activity = |(pin_sync ^ pin_hist);

  always_ff @(posedge clk) begin
    if (rst) wake <= 1'b0;
    else     wake <= enable & activity;
  end
endmodule

// File: rtl/gpio_port_cell.sv
module gpio_port_cell (
  input  logic clk,
  input  logic rst,
  input  logic data_bit,
  input  logic dir_bit,
  input  logic attr_bit,
  input  logic mask_bit,
  input  logic alt_sel,
  input  logic alt0_o,
  input  logic alt0_e,
  input  logic alt1_o,
  input  logic alt1_e,
  output logic oe,
  output logic out,
  output logic pull_en,
  output logic pull_up
);
  logic oe_d, out_d, pen_d, pup_d;

  always_comb begin
    oe_d  = 1'b0;
    out_d = 1'b0;
    pen_d = 1'b0;
    pup_d = 1'b0;
    if (mask_bit) begin
      oe_d  = alt_sel ? alt1_e : alt0_e;
      out_d = alt_sel ? alt1_o : alt0_o;
    end else if (dir_bit) begin
      oe_d  = 1'b1;
      out_d = attr_bit ? data_bit : ~data_bit;
    end else begin
      pen_d = ~attr_bit;
      pup_d = ~attr_bit & data_bit;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      oe      <= 1'b0;
      out     <= 1'b0;
      pull_en <= 1'b1;
      pull_up <= 1'b0;
    end else begin
      oe      <= oe_d;
      out     <= out_d;
      pull_en <= pen_d;
      pull_up <= pup_d;
    end
  end
endmodule

// File: rtl/gpio_port_ctl.sv
module gpio_port_ctl
  import gpio_port_pkg::*;
#(
  parameter int PIN_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bus_we,
  input  logic [REG_ADDR_W-1:0] bus_addr,
  input  logic [PIN_W-1:0]      bus_wdata,
  output logic [PIN_W-1:0]      bus_rdata,
  input  logic [PIN_W-1:0]      pin_in,
  input  logic [PIN_W-1:0]      alt0_out,
  input  logic [PIN_W-1:0]      alt0_oe,
  input  logic [PIN_W-1:0]      alt1_out,
  input  logic [PIN_W-1:0]      alt1_oe,
  output logic [PIN_W-1:0]      pad_oe,
  output logic [PIN_W-1:0]      pad_out,
  output logic [PIN_W-1:0]      pad_pull_en,
  output logic [PIN_W-1:0]      pad_pull_up,
  output logic                  wake_pulse
);
  logic [PIN_W-1:0] data_q, dir_q, attr_q, mask_q;
  logic [CFG_W-1:0] cfg_q;
  logic [PIN_W-1:0] pin_sync, pin_hist;

  gpio_port_sync #(.PIN_W(PIN_W), .STAGES(SYNC_STAGES)) sync_i (
    .clk      (clk),
    .rst      (rst),
    .pin_raw  (pin_in),
    .pin_sync (pin_sync),
    .pin_hist (pin_hist)
  );

  gpio_port_regs #(.PIN_W(PIN_W)) regs_i (
    .clk       (clk),
    .rst       (rst),
    .we        (bus_we),
    .addr      (bus_addr),
    .wdata     (bus_wdata),
    .pin_level (pin_sync),
    .rdata     (bus_rdata),
    .data_q    (data_q),
    .dir_q     (dir_q),
    .attr_q    (attr_q),
    .mask_q    (mask_q),
    .cfg_q     (cfg_q)
  );

  generate
    for (genvar p = 0; p < PIN_W; p++) begin : g_pin
      gpio_port_cell cell_i (
        .clk      (clk),
        .rst      (rst),
        .data_bit (data_q[p]),
        .dir_bit  (dir_q[p]),
        .attr_bit (attr_q[p]),
        .mask_bit (mask_q[p]),
        .alt_sel  (cfg_q[CFG_ALT_SEL]),
        .alt0_o   (alt0_out[p]),
        .alt0_e   (alt0_oe[p]),
        .alt1_o   (alt1_out[p]),
        .alt1_e   (alt1_oe[p]),
        .oe       (pad_oe[p]),
        .out      (pad_out[p]),
        .pull_en  (pad_pull_en[p]),
        .pull_up  (pad_pull_up[p])
      );
    end
  endgenerate

  gpio_port_wake #(.PIN_W(PIN_W)) wake_i (
    .clk      (clk),
    .rst      (rst),
    .enable   (cfg_q[CFG_WAKE_EN]),
    .pin_sync (pin_sync),
    .pin_hist (pin_hist),
    .wake     (wake_pulse)
  );
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
  import gpio_port_pkg::*;
#(
  parameter int PIN_W = 16
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  bus_we,
  input logic [REG_ADDR_W-1:0] bus_addr,
  input logic [PIN_W-1:0]      bus_rdata,
  input logic [PIN_W-1:0]      pad_oe,
  input logic [PIN_W-1:0]      pad_out,
  input logic [PIN_W-1:0]      pad_pull_en,
  input logic                  wake_pulse,
  input logic [PIN_W-1:0]      data_q,
  input logic [PIN_W-1:0]      dir_q,
  input logic [PIN_W-1:0]      attr_q,
  input logic [PIN_W-1:0]      mask_q,
  input logic [CFG_W-1:0]      cfg_q
);
  // R1: first cycle out of reset shows the idle state
  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pad_oe == '0 && !wake_pulse && bus_rdata == '0));

  // R6: a driven pin never has its pull enabled
  assert_no_pull_on_drive_R6: assert property (@(posedge clk) disable iff (rst)
    (pad_oe & pad_pull_en) == '0);

  // R3: inverted GPIO outputs drive the complement of the stored data
  assert_inverted_drive_R3: assert property (@(posedge clk) disable iff (rst)
    ($past(dir_q & ~mask_q & ~attr_q) & (pad_out ^ ~$past(data_q))) == '0);

  // R7: a direction read returns the stored direction one cycle later
  assert_dir_readback_R7: assert property (@(posedge clk) disable iff (rst)
    (!bus_we && bus_addr == ADDR_DIR) |=> (bus_rdata == $past(dir_q)));

  // R10: a wake pulse needs the enable held before its edge
  assert_wake_needs_enable_R10: assert property (@(posedge clk) disable iff (rst)
    wake_pulse |-> $past(cfg_q[CFG_WAKE_EN]));
endmodule

bind gpio_port_ctl gpio_port_chk #(.PIN_W(PIN_W)) chk_i (.*);

// File: tb/gpio_port_ctl_tb.sv
module gpio_port_ctl_tb_top;
  localparam int W = 16;
  localparam logic [W-1:0] A0O = 16'hA5A5, A0E = 16'h00FF;
  localparam logic [W-1:0] A1O = 16'h3C3C, A1E = 16'hF0F0;

  typedef struct packed {
    logic         sel;
    logic [W-1:0] mask;
    logic [W-1:0] data;
    logic [W-1:0] attr;
    logic [W-1:0] dir;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{1'b0, 16'h0000, 16'h00FF, 16'h0000, 16'hFFFF},
    '{1'b0, 16'h0000, 16'h1234, 16'hFFFF, 16'hFFFF},
    '{1'b0, 16'h0000, 16'h0F0F, 16'h00FF, 16'h0000},
    '{1'b0, 16'h0000, 16'hAAAA, 16'hCCCC, 16'hF0F0},
    '{1'b0, 16'hFF00, 16'h5555, 16'h0F0F, 16'h00FF},
    '{1'b1, 16'h0FF0, 16'h9876, 16'h3333, 16'h0F0F}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_we = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [W-1:0] bus_wdata = '0;
  logic [W-1:0] pin_in = '0;
  logic [W-1:0] bus_rdata, pad_oe, pad_out, pad_pull_en, pad_pull_up;
  logic wake_pulse;
  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  gpio_port_ctl dut_i (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .alt0_out(A0O), .alt0_oe(A0E), .alt1_out(A1O), .alt1_oe(A1E),
    .pad_oe(pad_oe), .pad_out(pad_out), .pad_pull_en(pad_pull_en),
    .pad_pull_up(pad_pull_up), .wake_pulse(wake_pulse)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [W-1:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Expected pad state from the requirements (R2..R6, R9)
  task automatic expect_pads(input vec_t v, output logic [W-1:0] oe,
                             output logic [W-1:0] o, output logic [W-1:0] pe,
                             output logic [W-1:0] pu);
    for (int b = 0; b < W; b++) begin
      if (v.mask[b]) begin
        oe[b] = v.sel ? A1E[b] : A0E[b];
        o[b]  = v.sel ? A1O[b] : A0O[b];
        pe[b] = 1'b0; pu[b] = 1'b0;
      end else if (v.dir[b]) begin
        oe[b] = 1'b1;
        o[b]  = v.attr[b] ? v.data[b] : !v.data[b];
        pe[b] = 1'b0; pu[b] = 1'b0;
      end else begin
        oe[b] = 1'b0; o[b] = 1'b0;
        pe[b] = !v.attr[b];
        pu[b] = !v.attr[b] && v.data[b];
      end
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [W-1:0] e_oe, e_o, e_pe, e_pu, r;
    idle(3);
    rst = 1'b0;
    // R1: reset state
    chk("R1 pad_oe", pad_oe, '0);
    chk("R1 pull_en", pad_pull_en, '1);
    chk("R1 pull_up", pad_pull_up, '0);
    chk("R1 wake", {15'd0, wake_pulse}, '0);
    chk("R1 rdata", bus_rdata, '0);

    // Table of configurations walked by one loop
    for (int k = 0; k < 6; k++) begin
      wr(3'd1, VECS[k].dir);
      wr(3'd2, VECS[k].attr);
      wr(3'd0, VECS[k].data);
      wr(3'd3, VECS[k].mask);
      wr(3'd5, {15'd0, VECS[k].sel});
      @(negedge clk);
      expect_pads(VECS[k], e_oe, e_o, e_pe, e_pu);
      chk("R2_R9 oe", pad_oe, e_oe);
      chk("R3_R4_R9 out", pad_out, e_o);
      chk("R5_R6 pull_en", pad_pull_en, e_pe);
      chk("R5 pull_up", pad_pull_up, e_pu);
      rd(3'd0, r);
      chk("R7 data read", r, VECS[k].data);
      rd(3'd3, r);
      chk("R7 mask read", r, VECS[k].mask);
    end
    rd(3'd5, r);
    chk("R7 cfg read", r, 16'h0001);

    // R8 and R10: pin read and wake pulse timing together
    wr(3'd5, 16'h0002);
    idle(2);
    bus_addr = 3'd4;
    pin_in = 16'h0010;
    @(negedge clk);
    @(negedge clk);
    chk("R10 wake before third edge", {15'd0, wake_pulse}, '0);
    chk("R8 pin read before third edge", bus_rdata, '0);
    @(negedge clk);
    chk("R10 wake at third edge", {15'd0, wake_pulse}, 16'd1);
    chk("R8 pin read at third edge", bus_rdata, 16'h0010);
    @(negedge clk);
    chk("R10 wake lasts one cycle", {15'd0, wake_pulse}, '0);

    // R10: disabled wake gives no pulse
    wr(3'd5, 16'h0000);
    idle(3);
    pin_in = 16'h0000;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R10 wake disabled", {15'd0, wake_pulse}, '0);
    end

    // R10: enable written on the edge where the change is detected
    pin_in = 16'h8001;
    @(negedge clk);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 3'd5; bus_wdata = 16'h0002;
    @(negedge clk);
    bus_we = 1'b0;
    chk("R10 same-edge enable no pulse", {15'd0, wake_pulse}, '0);
    @(negedge clk);
    chk("R10 same-edge enable after", {15'd0, wake_pulse}, '0);
    pin_in = 16'h8000;
    idle(3);
    chk("R10 enable now active", {15'd0, wake_pulse}, 16'd1);

    // R11: writes to read-only and unmapped addresses change nothing
    wr(3'd1, 16'h00FF);
    wr(3'd4, 16'hFFFF);
    wr(3'd6, 16'hFFFF);
    wr(3'd7, 16'hFFFF);
    @(negedge clk);
    chk("R11 pad_oe unchanged", pad_oe, 16'h00FF);
    rd(3'd6, r);
    chk("R11 read addr 6", r, '0);
    rd(3'd7, r);
    chk("R11 read addr 7", r, '0);
    rd(3'd4, r);
    chk("R11 pin read unchanged", r, 16'h8000);
    rd(3'd0, r);
    chk("R11 data unchanged", r, VECS[5].data);

    finish_run();
  end
endmodule